// File: doc/BRIEF.md
# Sprite Blitter DMA Engine

The block copies a rectangular sprite from a graphics ROM that holds one byte per pixel into a 512 x 512 frame buffer of 16-bit pixels. Software programs a bank of ten 16-bit registers and then writes the command register with its top bit set. The engine works out the clipped rectangle and the source addressing once. It then walks the sprite row by row, and for each pixel it reads one ROM byte and makes at most one frame-buffer write. Both memory ports use a ready handshake.

A four-bit pixel mode in the command word chooses how zero and non-zero source bytes are treated. Each class can be skipped, copied through the palette, or replaced by a solid color. A further command bit mirrors the sprite horizontally. At the end of a job the busy bit in the command register drops and the interrupt line rises. The interrupt stays high until the next command write.

Top module: `spr_blit`

## Requirements
- R1: The register bank has word offsets 0 command, 1 row stride, 2 source low, 3 source high, 4 X start, 5 Y start, 6 width, 7 height, 8 palette, 9 color. A read returns the current contents. Offsets 10 to 15 read as zero and ignore writes. All registers reset to zero.
- R2: A write to offset 0 with bit 15 set starts a job when the engine is idle. Bit 15 of offset 0 reads as 1 while the job runs. While the engine is busy, writes to every offset are ignored. When idle, `rom_req` and `vram_we` stay low.
- R3: Any command write made while idle drops `irq` on the next cycle. When a job ends, command bit 15 clears and `irq` rises on the same cycle and stays high.
- R4: Command bits 3:0 select the mode. 0 writes nothing. 1 writes zero bytes as P. 2 writes non-zero bytes as P|d. 3 writes every byte as P|d. 4/5 write zero bytes as C. 6/7 write zero bytes as C and others as P|d. 8/A write non-zero bytes as C. 9/B write non-zero bytes as C and zero bytes as P. C to F write C everywhere. Bytes that are not written leave no write on the frame-buffer port.
- R5: P is palette[7:0] placed in bits 15:8 with zero low byte. C is P ORed with color[7:0].
- R6: `vram_addr` is {y[8:0], x[8:0]}. Rows go top to bottom. The pixels of a row come from consecutive ROM bytes. The start of the next row advances by the effective stride (stride + width + 3) with bits 1:0 cleared. Stride, X and Y are signed, and width and height are unsigned.
- R7: {source high, source low} is a bit address. When it is below 0x02000000, 0x02000000 is added. The ROM byte address is (address − 0x02000000) >> 3.
- R8: When command bit 4 is set, X runs downward from X + width − 1. The source start moves back by width − 1 bytes, and the effective stride is (stride − width + 3) with bits 1:0 cleared.
- R9: A negative Y drops the first |Y| rows and advances the source by |Y| strides. Height is then limited so that Y + height ≤ 512.
- R10: Without the mirror, a negative X trims |X| columns and advances the source by |X| bytes. Width is then limited so that X + width ≤ 512.
- R11: With the mirror, a start X above 511 is clamped to 511, and the width and source are trimmed by the excess. If the width then exceeds the start X, it becomes equal to the start X.
- R12: Outside modes C to F, a row whose ROM byte start is at or above 0x06000000 is skipped with no reads or writes. In modes C to F it is drawn.
- R13: Mode 0, an empty clipped rectangle, and modes C to F make no ROM reads. Mode 0 and empty jobs still complete and raise `irq`.
- R14: `rom_req` holds with a stable `rom_addr` until `rom_ready`. `vram_we` holds with stable address and data until `vram_ready`. The two requests never overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| irq | output | 1 | Job-complete interrupt |
| rom_req | output | 1 | ROM read request |
| rom_addr | output | 32 | ROM byte address |
| rom_ready | input | 1 | ROM data valid, completes the read |
| rom_data | input | 8 | ROM byte |
| vram_we | output | 1 | Frame-buffer write request |
| vram_addr | output | 18 | Frame-buffer address {y, x} |
| vram_data | output | 16 | Frame-buffer pixel |
| vram_ready | input | 1 | Frame-buffer write accepted |

## Verification
Mirrored clipping at the right edge is the hardest case to reach. The start X plus width must pass 511 after the mirror shift, so that the clamp, the source trim and the width limit all act in one job. A second hard case is the mirror at the left edge, where the width is cut to the start X. The stimulus table programs sprites a few pixels wide placed just across each edge, and the bench compares the full write log, addresses and data, against a model. It also reaches the ROM-overrun row skip by placing a two-row sprite so that its second row starts exactly at the byte limit. It holds the ROM port stalled to observe the busy bit and the write lockout mid-job.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam int REG_N     = 10;
  localparam int RA_W      = 4;
  localparam int DW        = 16;
  localparam int PIX_W     = 8;
  localparam int FB_BITS   = 9;
  localparam int FB_SIDE   = 1 << FB_BITS;
  localparam int CNT_W     = FB_BITS + 1;
  localparam int SW        = FB_BITS + 9;
  localparam int SA_W      = 32;
  localparam int MODE_W    = 4;
  localparam int FILL_MODE = 12;
  localparam logic [SA_W-1:0] ROM_BASE  = 32'h0200_0000;
  localparam logic [SA_W-1:0] ROM_LIMIT = 32'h0600_0000;

  typedef struct packed {
    logic [DW-1:0] cmd;
    logic [DW-1:0] stride;
    logic [DW-1:0] src_lo;
    logic [DW-1:0] src_hi;
    logic [DW-1:0] xs;
    logic [DW-1:0] ys;
    logic [DW-1:0] wid;
    logic [DW-1:0] hgt;
    logic [DW-1:0] pal;
    logic [DW-1:0] col;
  } blit_regs_t;

  typedef struct packed {
    logic [MODE_W-1:0]  mode;
    logic               flip;
    logic [SA_W-1:0]    src;
    logic [SA_W-1:0]    step;
    logic [FB_BITS-1:0] x;
    logic [FB_BITS-1:0] y;
    logic [CNT_W-1:0]   w;
    logic [CNT_W-1:0]   h;
    logic [DW-1:0]      pal_v;
    logic [DW-1:0]      col_v;
  } blit_job_t;

  // Resolve stride, mirror shift, clipping and source start once per job.
  function automatic blit_job_t plan_job(blit_regs_t r);
    blit_job_t j;
    logic signed [SW-1:0] px, py, pw, ph, over;
    logic [SA_W-1:0] st, bitad, src, wext;
    j      = '0;
    j.mode = r.cmd[MODE_W-1:0];
    j.flip = r.cmd[4];
    px     = SW'($signed(r.xs));
    py     = SW'($signed(r.ys));
    pw     = $signed({{(SW-DW){1'b0}}, r.wid});
    ph     = $signed({{(SW-DW){1'b0}}, r.hgt});
    wext   = {{(SA_W-DW){1'b0}}, r.wid};
    st     = $unsigned(SA_W'($signed(r.stride)));
    bitad  = {r.src_hi, r.src_lo};
    if (j.flip) begin
      bitad = bitad - ((wext - 32'd1) << 3);
      st    = st - wext + 32'd3;
      px    = px + pw - SW'(1);
    end else begin
      st    = st + wext + 32'd3;
    end
    st = st & ~32'd3;
    if (bitad < ROM_BASE) bitad = bitad + ROM_BASE;
    src = (bitad - ROM_BASE) >> 3;
    if (py < 0) begin
      ph  = ph + py;
      src = src + $unsigned(SA_W'(-py)) * st;
      py  = '0;
    end
    if (py + ph > SW'(FB_SIDE)) ph = SW'(FB_SIDE) - py;
    if (!j.flip) begin
      if (px < 0) begin
        pw  = pw + px;
        src = src + $unsigned(SA_W'(-px));
        px  = '0;
      end
      if (px + pw > SW'(FB_SIDE)) pw = SW'(FB_SIDE) - px;
    end else begin
      if (px > SW'(FB_SIDE - 1)) begin
        over = px - SW'(FB_SIDE - 1);
        pw   = pw - over;
        src  = src + $unsigned(SA_W'(over));
        px   = SW'(FB_SIDE - 1);
      end
      if (px - pw < 0) pw = px;
    end
    j.w     = (pw > 0) ? CNT_W'(pw) : '0;
    j.h     = (ph > 0) ? CNT_W'(ph) : '0;
    j.x     = px[FB_BITS-1:0];
    j.y     = py[FB_BITS-1:0];
    j.src   = src;
    j.step  = st;
    j.pal_v = {r.pal[7:0], 8'h00};
    j.col_v = {r.pal[7:0], r.col[7:0]};
    return j;
  endfunction

  // {write, value} for one source byte under a mode.
  function automatic logic [DW:0] pixel_out(logic [MODE_W-1:0] mode, logic [PIX_W-1:0] d,
                                            logic [DW-1:0] pal_v, logic [DW-1:0] col_v);
    logic z;
    logic [DW-1:0] cp;
    z  = (d == '0);
    cp = pal_v | {{(DW-PIX_W){1'b0}}, d};
    case (mode)
      4'h0:        pixel_out = '0;
      4'h1:        pixel_out = {z, pal_v};
      4'h2:        pixel_out = {!z, cp};
      4'h3:        pixel_out = {1'b1, cp};
      4'h4, 4'h5:  pixel_out = {z, col_v};
      4'h6, 4'h7:  pixel_out = {1'b1, z ? col_v : cp};
      4'h8, 4'hA:  pixel_out = {!z, col_v};
      4'h9, 4'hB:  pixel_out = {1'b1, z ? cp : col_v};
      default:     pixel_out = {1'b1, col_v};
    endcase
  endfunction
endpackage

// File: rtl/blit_regs.sv
module blit_regs
  import blit_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [RA_W-1:0] addr,
  input  logic [DW-1:0]   wdata,
  input  logic            busy,
  input  logic            done_evt,
  output logic [DW-1:0]   rdata,
  output blit_regs_t      regs_o,
  output logic            start_evt,
  output logic            irq
);
  logic [DW-1:0] bank [REG_N];
  logic cmd_wr;

  assign cmd_wr    = we && !busy && (addr == RA_W'(0));
  assign start_evt = cmd_wr && wdata[DW-1];

  for (genvar g = 0; g < REG_N; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank[g] <= '0;
      end else if (we && !busy && addr == RA_W'(g)) begin
        bank[g] <= wdata;
      end else if (g == 0 && done_evt) begin
        bank[g] <= {1'b0, bank[g][DW-2:0]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        irq <= 1'b0;
    else if (done_evt) irq <= 1'b1;
    else if (cmd_wr)   irq <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < REG_N; i++)
      if (addr == RA_W'(i)) rdata = bank[i];
  end

  assign regs_o = {bank[0], bank[1], bank[2], bank[3], bank[4],
                   bank[5], bank[6], bank[7], bank[8], bank[9]};
endmodule

// File: rtl/blit_plan.sv
module blit_plan
  import blit_pkg::*;
(
  input  blit_regs_t     regs_i,
  input  logic [DW-1:0]  cmd_i,
  output blit_job_t      job_o
);
  blit_regs_t eff;
  always_comb begin
    eff     = regs_i;
    eff.cmd = cmd_i;
    job_o   = plan_job(eff);
  end
endmodule

// File: rtl/blit_walk.sv
module blit_walk
  import blit_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  blit_job_t           job_in,
  output logic                busy,
  output logic                done_evt,
  output logic                fill_only,
  output logic                rom_req,
  output logic [SA_W-1:0]     rom_addr,
  input  logic                rom_ready,
  input  logic [PIX_W-1:0]    rom_data,
  output logic                vram_we,
  output logic [2*FB_BITS-1:0] vram_addr,
  output logic [DW-1:0]       vram_data,
  input  logic                vram_ready
);
  typedef enum logic [2:0] {W_IDLE, W_ROW, W_RD, W_WR, W_END} wst_t;
  wst_t state;
  blit_job_t job;
  logic [CNT_W-1:0]   row_n, col_n;
  logic [SA_W-1:0]    row_src, pix_src;
  logic [FB_BITS-1:0] cx, cy;
  logic [DW-1:0]      wdat;
  logic [DW:0]        pix;
  logic step, last_col, skip_row, row_end;

  assign fill_only = (job.mode >= MODE_W'(FILL_MODE));
  assign pix       = pixel_out(job.mode, rom_data, job.pal_v, job.col_v);
  assign last_col  = (col_n + CNT_W'(1) == job.w);
  assign skip_row  = (row_src >= ROM_LIMIT) && !fill_only;
  assign row_end   = (row_n == job.h) || (job.w == '0) || (job.mode == '0);
  assign step      = (state == W_RD && rom_ready && !pix[DW]) ||
                     (state == W_WR && vram_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= W_IDLE;
      job     <= '0;
      row_n   <= '0;
      col_n   <= '0;
      row_src <= '0;
      pix_src <= '0;
      cx      <= '0;
      cy      <= '0;
      wdat    <= '0;
    end else begin
      case (state)
        W_IDLE: if (start) begin
          job     <= job_in;
          row_n   <= '0;
          row_src <= job_in.src;
          cy      <= job_in.y;
          state   <= W_ROW;
        end
        W_ROW: begin
          if (row_end) begin
            state <= W_END;
          end else if (skip_row) begin
            row_n   <= row_n + CNT_W'(1);
            row_src <= row_src + job.step;
            cy      <= cy + FB_BITS'(1);
          end else begin
            pix_src <= row_src;
            cx      <= job.x;
            col_n   <= '0;
            wdat    <= job.col_v;
            state   <= fill_only ? W_WR : W_RD;
          end
        end
        W_RD: if (rom_ready && pix[DW]) begin
          wdat  <= pix[DW-1:0];
          state <= W_WR;
        end
        W_END:   state <= W_IDLE;
        default: ;
      endcase
      if (step) begin
        if (last_col) begin
          row_n   <= row_n + CNT_W'(1);
          row_src <= row_src + job.step;
          cy      <= cy + FB_BITS'(1);
          state   <= W_ROW;
        end else begin
          col_n   <= col_n + CNT_W'(1);
          pix_src <= pix_src + 32'd1;
          cx      <= job.flip ? cx - FB_BITS'(1) : cx + FB_BITS'(1);
          state   <= fill_only ? W_WR : W_RD;
        end
      end
    end
  end

  assign busy      = (state != W_IDLE);
  assign done_evt  = (state == W_END);
  assign rom_req   = (state == W_RD);
  assign rom_addr  = pix_src;
  assign vram_we   = (state == W_WR);
  assign vram_addr = {cy, cx};
  assign vram_data = wdat;
endmodule

// File: rtl/spr_blit.sv
module spr_blit
  import blit_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [RA_W-1:0]      reg_addr,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata,
  output logic                 irq,
  output logic                 rom_req,
  output logic [SA_W-1:0]      rom_addr,
  input  logic                 rom_ready,
  input  logic [PIX_W-1:0]     rom_data,
  output logic                 vram_we,
  output logic [2*FB_BITS-1:0] vram_addr,
  output logic [DW-1:0]        vram_data,
  input  logic                 vram_ready
);
  blit_regs_t regs;
  blit_job_t  job;
  logic busy, start_evt, done_evt, fill_only;

  blit_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .busy(busy), .done_evt(done_evt), .rdata(reg_rdata), .regs_o(regs),
    .start_evt(start_evt), .irq(irq)
  );

  blit_plan u_plan (.regs_i(regs), .cmd_i(reg_wdata), .job_o(job));

  blit_walk u_walk (
    .clk(clk), .rst_n(rst_n), .start(start_evt), .job_in(job), .busy(busy),
    .done_evt(done_evt), .fill_only(fill_only), .rom_req(rom_req),
    .rom_addr(rom_addr), .rom_ready(rom_ready), .rom_data(rom_data),
    .vram_we(vram_we), .vram_addr(vram_addr), .vram_data(vram_data),
    .vram_ready(vram_ready)
  );
endmodule

// File: rtl/blit_chk.sv
module blit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [3:0]  reg_addr,
  input logic        irq,
  input logic        rom_req,
  input logic [31:0] rom_addr,
  input logic        rom_ready,
  input logic        vram_we,
  input logic [17:0] vram_addr,
  input logic [15:0] vram_data,
  input logic        vram_ready,
  input logic        busy,
  input logic        start_evt,
  input logic        done_evt,
  input logic        fill_only
);
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rom_req && !vram_we));
  p_irq_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 4'd0 && !busy) |=> !irq);
  p_irq_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (irq && !busy));
  p_fill_noread_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fill_only) |-> !rom_req);
  p_rom_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_req && !rom_ready) |=> (rom_req && $stable(rom_addr)));
  p_vram_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (vram_we && !vram_ready) |=> (vram_we && $stable(vram_addr) && $stable(vram_data)));
  p_one_port_r14: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_req && vram_we));
endmodule

bind spr_blit blit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .irq(irq),
  .rom_req(rom_req), .rom_addr(rom_addr), .rom_ready(rom_ready),
  .vram_we(vram_we), .vram_addr(vram_addr), .vram_data(vram_data),
  .vram_ready(vram_ready), .busy(busy), .start_evt(start_evt),
  .done_evt(done_evt), .fill_only(fill_only)
);

// File: tb/sim_spr_blit.sv
`timescale 1ns/1ps
module sim_spr_blit;
  localparam int NV = 22;
  localparam int LOGN = 64;
  localparam logic [159:0] VEC [NV] = '{
    {16'h8003,16'h0000,16'h0080,16'h0200,16'd10, 16'd20, 16'd3,16'd2,16'h0012,16'h0034},
    {16'h8001,16'h0000,16'h0080,16'h0200,16'd10, 16'd20, 16'd3,16'd2,16'h0012,16'h0034},
    {16'h8002,16'h0000,16'h0080,16'h0200,16'd10, 16'd20, 16'd3,16'd2,16'h0012,16'h0034},
    {16'h8006,16'h0000,16'h0080,16'h0200,16'd10, 16'd20, 16'd3,16'd2,16'h0012,16'h0034},
    {16'h8009,16'h0005,16'h0080,16'h0200,16'd10, 16'd20, 16'd3,16'd2,16'h0012,16'h0034},
    {16'h800C,16'h0000,16'h0080,16'h0200,16'd10, 16'd20, 16'd3,16'd2,16'h0012,16'h0034},
    {16'h8013,16'h0008,16'h0080,16'h0200,16'd100,16'd5,  16'd4,16'd2,16'h0021,16'h0043},
    {16'h8003,16'h0000,16'h0080,16'h0200,16'd10, 16'hFFFF,16'd3,16'd3,16'h0012,16'h0034},
    {16'h8003,16'h0000,16'h0080,16'h0200,16'hFFFE,16'd7, 16'd4,16'd1,16'h0012,16'h0034},
    {16'h8003,16'h0000,16'h0080,16'h0200,16'd510,16'd7,  16'd4,16'd1,16'h0012,16'h0034},
    {16'h8013,16'h0000,16'h0080,16'h0200,16'd509,16'd9,  16'd4,16'd1,16'h0012,16'h0034},
    {16'h8013,16'h0000,16'h0080,16'h0200,16'hFFFF,16'd9, 16'd4,16'd1,16'h0012,16'h0034},
    {16'h8003,16'h0000,16'h0080,16'h0200,16'd3,  16'd510,16'd2,16'd4,16'h0012,16'h0034},
    {16'h8003,16'h0000,16'h0040,16'h0000,16'd3,  16'd3,  16'd3,16'd1,16'h0055,16'h0034},
    {16'h8003,16'h0000,16'hFFE0,16'h31FF,16'd60, 16'd60, 16'd2,16'd2,16'h0012,16'h0034},
    {16'h8000,16'h0000,16'h0080,16'h0200,16'd10, 16'd20, 16'd3,16'd2,16'h0012,16'h0034},
    {16'h800F,16'h0000,16'hFFE0,16'h31FF,16'd60, 16'd60, 16'd2,16'd2,16'h0012,16'h0077},
    {16'h8003,16'hFFF0,16'h0400,16'h0200,16'd30, 16'd40, 16'd2,16'd2,16'h0012,16'h0034},
    {16'h800A,16'h0000,16'h0080,16'h0200,16'd10, 16'd20, 16'd3,16'd2,16'h0012,16'h0034},
    {16'h8005,16'h0000,16'h0080,16'h0200,16'd10, 16'd20, 16'd3,16'd2,16'h0012,16'h00F4},
    {16'h8007,16'h0000,16'h0080,16'h0200,16'd10, 16'd20, 16'd3,16'd2,16'hFF12,16'hAB34},
    {16'h800B,16'h0000,16'h0080,16'h0200,16'd10, 16'd20, 16'd3,16'd2,16'h0012,16'h0034}
  };

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [3:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic irq, rom_req, rom_ready, vram_we, vram_ready;
  logic [31:0] rom_addr;
  logic [7:0] rom_data;
  logic [17:0] vram_addr;
  logic [15:0] vram_data;
  logic stall = 0;
  logic [3:0] pat = 0;
  int checks = 0, fails = 0;
  bit finished = 0;
  int nw = 0, nr = 0, ne = 0, enr = 0;
  logic [17:0] la [LOGN];
  logic [15:0] ld [LOGN];
  logic [17:0] ea [LOGN];
  logic [15:0] ed [LOGN];

  always #4 clk = ~clk;

  function automatic logic [7:0] romf(logic [31:0] a);
    return (a % 3 == 0) ? 8'h00 : ({1'b0, a[6:0]} | 8'h80);
  endfunction

  assign rom_data   = romf(rom_addr);
  assign rom_ready  = rom_req && !stall && (pat[0] | pat[2]);
  assign vram_ready = vram_we && (pat[1] | ~pat[0]);

  always @(posedge clk) pat <= pat + 4'd3;

  always @(negedge clk) begin
    if (vram_we && vram_ready) begin
      if (nw < LOGN) begin la[nw] = vram_addr; ld[nw] = vram_data; end
      nw++;
    end
    if (rom_req && rom_ready) nr++;
  end

  spr_blit u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .rom_req(rom_req), .rom_addr(rom_addr), .rom_ready(rom_ready),
    .rom_data(rom_data), .vram_we(vram_we), .vram_addr(vram_addr),
    .vram_data(vram_data), .vram_ready(vram_ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_irq(input string tag);
    int n = 0;
    while (!irq && n < 4000) begin @(negedge clk); n++; end
    chk({tag, " irq at end of job (R3)"}, {31'd0, irq}, 32'd1);
  endtask

  // Per-class action table: zero-byte action and non-zero-byte action.
  // 0 none, 1 palette base, 2 palette|byte, 3 solid color.
  function automatic int zero_act(int m);
    if (m == 1 || m == 3 || m == 9 || m == 11) return 1;
    if ((m >= 4 && m <= 7) || m >= 12) return 3;
    return 0;
  endfunction
  function automatic int nz_act(int m);
    if (m == 2 || m == 3 || m == 6 || m == 7) return 2;
    if (m >= 8) return 3;
    return 0;
  endfunction

  task automatic model(input logic [159:0] v);
    logic [15:0] f [10];
    logic [31:0] b, s, ro, a;
    logic [15:0] pal, col;
    logic [7:0] px;
    int mode, w, h, x, y, st, act, xx;
    bit flip;
    for (int i = 0; i < 10; i++) f[i] = v[159-16*i -: 16];
    mode = int'(f[0][3:0]); flip = f[0][4];
    w = int'(f[6]); h = int'(f[7]);
    x = int'($signed(f[4])); y = int'($signed(f[5]));
    pal = {f[8][7:0], 8'h00};
    col = pal | {8'h00, f[9][7:0]};
    b = {f[3], f[2]};
    if (flip) begin
      b = b - 32'((w - 1) * 8);
      st = int'($signed(f[1])) - w + 3;
      x = x + w - 1;
    end else st = int'($signed(f[1])) + w + 3;
    st = st & -4;
    if (b < 32'h0200_0000) b = b + 32'h0200_0000;
    s = (b - 32'h0200_0000) >> 3;
    if (y < 0) begin h = h + y; s = s + 32'(longint'(-y) * st); y = 0; end
    if (y + h > 512) h = 512 - y;
    if (!flip) begin
      if (x < 0) begin w = w + x; s = s + 32'(-x); x = 0; end
      if (x + w > 512) w = 512 - x;
    end else begin
      if (x > 511) begin w = w - (x - 511); s = s + 32'(x - 511); x = 511; end
      if (x < w) w = x;
    end
    ne = 0; enr = 0;
    if (mode == 0 || w <= 0 || h <= 0) return;
    for (int r = 0; r < h; r++) begin
      ro = s + 32'(r * st);
      if (ro >= 32'h0600_0000 && mode < 12) continue;
      for (int c = 0; c < w; c++) begin
        a = ro + 32'(c);
        px = romf(a);
        if (mode < 12) enr++;
        act = (px == 0) ? zero_act(mode) : nz_act(mode);
        xx = flip ? x - c : x + c;
        if (act != 0 && ne < LOGN) begin
          ea[ne] = {9'(y + r), 9'(xx)};
          ed[ne] = (act == 3) ? col : (act == 1) ? pal : (pal | {8'h00, px});
          ne++;
        end
      end
    end
  endtask

  function automatic string vtag(int i);
    case (i)
      0: return "R4 R5 R6 mode3";
      1: return "R4 mode1";
      2: return "R4 mode2";
      3: return "R4 mode6";
      4: return "R4 R6 mode9 stride";
      5: return "R13 mode C fill";
      6: return "R8 mirror";
      7: return "R9 top clip";
      8: return "R10 left clip";
      9: return "R10 right clip";
      10: return "R11 mirror right clamp";
      11: return "R11 mirror left limit";
      12: return "R9 bottom clip";
      13: return "R7 low source address";
      14: return "R12 overrun row skip";
      15: return "R13 mode0";
      16: return "R12 fill ignores overrun";
      17: return "R6 negative stride";
      18: return "R4 modeA";
      19: return "R4 R5 mode5";
      20: return "R4 R5 mode7 high bytes";
      default: return "R4 modeB R14";
    endcase
  endfunction

  initial begin
    #(8ns * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // Reset state
    for (int i = 0; i < 10; i++) begin
      rd(4'(i), d);
      chk("R1 reset register value", {16'd0, d}, 32'd0);
    end
    chk("R3 irq low after reset", {31'd0, irq}, 32'd0);
    chk("R2 no requests when idle", {30'd0, rom_req, vram_we}, 32'd0);
    // R1: readback and unmapped offsets
    wr(4'd3, 16'hBEEF); rd(4'd3, d);
    chk("R1 readback offset 3", {16'd0, d}, 32'h0000BEEF);
    wr(4'd12, 16'h1234); rd(4'd12, d);
    chk("R1 unmapped offset reads zero", {16'd0, d}, 32'd0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      model(VEC[i]);
      nw = 0; nr = 0;
      for (int k = 1; k < 10; k++) wr(4'(k), VEC[i][159-16*k -: 16]);
      wr(4'd0, VEC[i][159 -: 16]);
      wait_irq(vtag(i));
      repeat (2) @(negedge clk);
      chk({vtag(i), " write count"}, 32'(nw), 32'(ne));
      for (int k = 0; k < ne && k < LOGN; k++) begin
        chk({vtag(i), " write address"}, {14'd0, la[k]}, {14'd0, ea[k]});
        chk({vtag(i), " write data"}, {16'd0, ld[k]}, {16'd0, ed[k]});
      end
      chk({vtag(i), " ROM read count"}, 32'(nr), 32'(enr));
      rd(4'd0, d);
      chk({vtag(i), " busy bit cleared (R3)"}, {31'd0, d[15]}, 32'd0);
    end

    // R2: busy bit visible and writes locked out while running
    wr(4'd4, 16'd5); wr(4'd5, 16'd5); wr(4'd6, 16'd1); wr(4'd7, 16'd1);
    stall = 1;
    wr(4'd0, 16'h8003);
    rd(4'd0, d);
    chk("R2 busy bit set during job", {31'd0, d[15]}, 32'd1);
    wr(4'd4, 16'h0055);
    wr(4'd0, 16'h0000);
    rd(4'd0, d);
    chk("R2 command write ignored while busy", {16'd0, d}, 32'h00008003);
    stall = 0;
    wait_irq("R2 stalled job");
    rd(4'd4, d);
    chk("R2 X start kept after busy write", {16'd0, d}, 32'd5);
    rd(4'd0, d);
    chk("R3 command reads with bit 15 clear", {16'd0, d}, 32'h00000003);
    // R3: plain command write drops irq
    wr(4'd0, 16'h0000);
    chk("R3 irq dropped by command write", {31'd0, irq}, 32'd0);
    rd(4'd0, d);
    chk("R3 no job from bit15 clear", {31'd0, d[15]}, 32'd0);
    chk("R2 idle after non-start write", {30'd0, rom_req, vram_we}, 32'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule